// File: doc/BRIEF.md
# Register Block with Typed Fields on an APB Subordinate Port

This block is an APB subordinate that holds four 32-bit registers. Each register has its own access kind. A control register is read-write and drives the hardware. A status register is read-only and reflects a hardware input. A command register is write-only and fires a one-cycle pulse toward the hardware. An interrupt register is write-1-to-clear and is set by hardware events. Each transfer takes a fixed number of wait states, set by a parameter, before it completes.

A small state machine paces every transfer through three states.
- `ST_IDLE`: waits for a SETUP cycle.
- `ST_WAIT`: counts the wait states with `pready` low.
- `ST_DONE`: the single completing cycle with `pready` high.

The transitions are:
- `ST_IDLE` → `ST_WAIT` on SETUP when the wait count is non-zero.
- `ST_IDLE` → `ST_DONE` on SETUP when the wait count is zero.
- `ST_WAIT` → `ST_DONE` when the wait counter reaches zero.
- `ST_WAIT` → `ST_WAIT` while the counter is still counting down.
- `ST_DONE` → `ST_IDLE` always.

Address decode and error capture are sampled at the SETUP edge. Read data is also latched at the SETUP edge and held through the access. Register updates happen only on the completing edge, so each write commits once.

Top module: `apb_typed_regs`

## Requirements
- R1: A write commits exactly once per transfer, on the edge where `psel`, `penable`, `pwrite` and `pready` are all 1, whatever the wait-state count. A command write therefore yields exactly one `cmd_pulse`.
- R2: `pready` is 0 out of reset. After SETUP, exactly `WAIT_CYCLES` access cycles pass with `pready` = 0, then one cycle with `pready` = 1. `pready` returns to 0 in the cycle after completion.
- R3: Bit `pstrb[b]` gates bits `[8b+7:8b]` of the write. Bytes whose strobe is 0 keep their previous value, in the control register, the command data and the interrupt clear mask.
- R4: The interrupt register (offset 0x0C, bits [7:0]) updates as `new = (old & ~(wdata & strobes)) | hw_irq_set`. A hardware set and a software clear of the same bit in the same cycle leave the bit set. `irq_out` is the OR of all pending bits.
- R5: The status register (offset 0x04) returns `hw_status` and ignores writes; a write to it ends with `pslverr` = 1. Reserved bits read as 0 and never store data: control bits [31:24] and interrupt bits [31:8].
- R6: Any offset other than 0x00, 0x04, 0x08 and 0x0C completes normally with `pslverr` = 1. A read of such an offset returns 0, and a write changes no state.
- R7: `prdata` is 0 unless `psel` and `penable` are both 1. During an access it holds the value captured at SETUP and is stable while `pready` is 0.
- R8: `pslverr` is 1 only in a completing cycle and is 0 at all other times.
- R9: `presetn` is active-low and asynchronous. It clears the control register, command data, interrupt register, `pready`, `prdata` and `cmd_pulse` to 0.
- R10: Decode uses the word index `paddr[ADDR_W-1:2]`, and `paddr[1:0]` is ignored. The offsets are: control 0x00, status 0x04, command 0x08, interrupt 0x0C.
- R11: A write to the command register (offset 0x08) updates `cmd_data` lane by lane. `cmd_pulse` is 1 for exactly the one cycle after the completing edge. Reads of the command register return 0 with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Subordinate select |
| penable | input | 1 | Access phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte-lane write strobes |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer completion |
| pslverr | output | 1 | Error response at completion |
| hw_status | input | 32 | Value returned by the status register |
| hw_irq_set | input | IRQ_W | Per-bit interrupt set events |
| ctrl_out | output | 32 | Control register contents |
| cmd_pulse | output | 1 | One-cycle command strobe |
| cmd_data | output | 32 | Command register contents |
| irq_out | output | 1 | Any interrupt pending |

## Verification
A hardware interrupt set and a software write-1-to-clear can land on the same bit in the same completing cycle.

The bench provokes this by holding `hw_irq_set` on bit 3 through an entire clearing write, including its completing edge. It then reads the register back and expects bit 3 still set and `irq_out` still high. A later clear, with the set input released, must then remove the bit.

A per-cycle behavioural model tracks the interrupt bits independently of the design and compares `irq_out` against them on every clock. This catches both a lost set and a clear applied more than once.

// File: rtl/apb_regs_pkg.sv
package apb_regs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } bus_state_e;

    localparam int NUM_REGS = 4;
    localparam int IDX_CTRL = 0;
    localparam int IDX_STAT = 1;
    localparam int IDX_CMD  = 2;
    localparam int IDX_IRQ  = 3;

endpackage

// File: rtl/apb_wait_fsm.sv
module apb_wait_fsm
    import apb_regs_pkg::*;
#(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic pready,
    output logic setup_hit
);
    localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = (WAIT_CYCLES > 0) ? CNT_W'(WAIT_CYCLES - 1) : '0;

    bus_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (psel && !penable) begin
                    if (WAIT_CYCLES == 0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_WAIT;
                        cnt_d   = CNT_LOAD;
                    end
                end
            end
            ST_WAIT: begin
                if (cnt_q == '0) state_d = ST_DONE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pready    = (state_q == ST_DONE);
        setup_hit = (state_q == ST_IDLE) && psel && !penable;
    end

    // R2: completion lasts one cycle
    p_pready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pready |=> !pready);

    // R2: completion only follows a selected transfer
    p_pready_after_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pready) |-> $past(psel));

endmodule

// File: rtl/apb_reg_decode.sv
module apb_reg_decode
    import apb_regs_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0]    word_idx,
    input  logic                is_write,
    output logic [NUM_REGS-1:0] sel,
    output logic                mapped,
    output logic                bad_access
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel[g] = (word_idx == IDX_W'(g));
    end

    always_comb begin
        mapped     = |sel;
        bad_access = !mapped || (is_write && sel[IDX_STAT]);
    end

endmodule

// File: rtl/apb_reg_bank.sv
module apb_reg_bank
    import apb_regs_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                IRQ_W     = 8,
    parameter logic [DATA_W-1:0] CTRL_MASK = 32'h00FF_FFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                setup_hit,
    input  logic                commit,
    input  logic [NUM_REGS-1:0] sel,
    input  logic                bad_access,
    input  logic                is_write,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] strb,
    input  logic [DATA_W-1:0]   hw_status,
    input  logic [IRQ_W-1:0]    hw_irq_set,
    output logic [DATA_W-1:0]   rdata_q,
    output logic                err_q,
    output logic [DATA_W-1:0]   ctrl_q,
    output logic [IRQ_W-1:0]    irq_q,
    output logic [DATA_W-1:0]   cmd_q,
    output logic                cmd_pulse_q
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] rd_mux;
    logic [IRQ_W-1:0]  irq_clr;
    logic              wr_ctrl, wr_cmd, wr_irq;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_mask[b*8 +: 8] = {8{strb[b]}};
    end

    always_comb begin
        wr_ctrl = commit && sel[IDX_CTRL];
        wr_cmd  = commit && sel[IDX_CMD];
        wr_irq  = commit && sel[IDX_IRQ];
        irq_clr = wr_irq ? (wdata[IRQ_W-1:0] & lane_mask[IRQ_W-1:0]) : '0;
        rd_mux  = '0;
        if (sel[IDX_CTRL])      rd_mux = ctrl_q;
        else if (sel[IDX_STAT]) rd_mux = hw_status;
        else if (sel[IDX_IRQ])  rd_mux = DATA_W'(irq_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            cmd_q       <= '0;
            cmd_pulse_q <= 1'b0;
            irq_q       <= '0;
            rdata_q     <= '0;
            err_q       <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ((ctrl_q & ~lane_mask) | (wdata & lane_mask)) & CTRL_MASK;
            if (wr_cmd)  cmd_q  <= (cmd_q & ~lane_mask) | (wdata & lane_mask);
            cmd_pulse_q <= wr_cmd;
            irq_q       <= (irq_q & ~irq_clr) | hw_irq_set;
            if (setup_hit) begin
                rdata_q <= is_write ? '0 : rd_mux;
                err_q   <= bad_access;
            end
        end
    end

    // R1: one command strobe per write
    p_cmd_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse_q |=> !cmd_pulse_q);

    // R4: a pending bit only appears after a hardware set
    p_irq_rise_needs_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q & ~$past(irq_q) & ~$past(hw_irq_set)) == '0);

endmodule

// File: rtl/apb_typed_regs.sv
module apb_typed_regs
    import apb_regs_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          IRQ_W       = 8,
    parameter int          WAIT_CYCLES = 2,
    parameter logic [31:0] CTRL_MASK   = 32'h00FF_FFFF
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [3:0]        pstrb,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [31:0]       hw_status,
    input  logic [IRQ_W-1:0]  hw_irq_set,
    output logic [31:0]       ctrl_out,
    output logic              cmd_pulse,
    output logic [31:0]       cmd_data,
    output logic              irq_out
);
    localparam int IDX_W = ADDR_W - 2;

    logic [NUM_REGS-1:0] sel;
    logic                mapped, bad_access, setup_hit, commit, err_q;
    logic [31:0]         rdata_q;
    logic [IRQ_W-1:0]    irq_q;
    logic [1:0]          unused_lsb;

    assign unused_lsb = paddr[1:0];

    apb_wait_fsm #(.WAIT_CYCLES(WAIT_CYCLES)) u_fsm (
        .clk(pclk), .rst_n(presetn), .psel(psel), .penable(penable),
        .pready(pready), .setup_hit(setup_hit)
    );

    apb_reg_decode #(.IDX_W(IDX_W)) u_dec (
        .word_idx(paddr[ADDR_W-1:2]), .is_write(pwrite),
        .sel(sel), .mapped(mapped), .bad_access(bad_access)
    );

    apb_reg_bank #(.DATA_W(32), .IRQ_W(IRQ_W), .CTRL_MASK(CTRL_MASK)) u_bank (
        .clk(pclk), .rst_n(presetn), .setup_hit(setup_hit), .commit(commit),
        .sel(sel), .bad_access(bad_access), .is_write(pwrite),
        .wdata(pwdata), .strb(pstrb), .hw_status(hw_status),
        .hw_irq_set(hw_irq_set), .rdata_q(rdata_q), .err_q(err_q),
        .ctrl_q(ctrl_out), .irq_q(irq_q), .cmd_q(cmd_data),
        .cmd_pulse_q(cmd_pulse)
    );

    always_comb begin
        commit  = psel && penable && pwrite && pready;
        prdata  = (psel && penable) ? rdata_q : '0;
        pslverr = psel && penable && pready && err_q;
        irq_out = |irq_q;
    end

    // R7: read data does not move while the access is waiting
    p_prdata_stable_r7: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && $past(psel && penable && !pready)) |-> $stable(prdata));

    // R6: a write to an unmapped offset leaves the stored state alone
    p_unmapped_no_write_r6: assert property (@(posedge pclk) disable iff (!presetn)
        (commit && !mapped) |=> ($stable(ctrl_out) && $stable(cmd_data)));

endmodule

// File: tb/sim_apb_typed_regs.sv
module sim_apb_typed_regs;
    localparam int          AW    = 8;
    localparam int          IW    = 8;
    localparam int          WAITS = 2;
    localparam logic [31:0] CMASK = 32'h00FF_FFFF;

    logic          pclk = 1'b0, presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0, hw_status = '0;
    logic [3:0]    pstrb = '0;
    logic [IW-1:0] hw_irq_set = '0;
    logic [31:0]   prdata, ctrl_out, cmd_data;
    logic          pready, pslverr, cmd_pulse, irq_out;

    apb_typed_regs #(.ADDR_W(AW), .IRQ_W(IW), .WAIT_CYCLES(WAITS), .CTRL_MASK(CMASK)) u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
        .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .hw_status(hw_status), .hw_irq_set(hw_irq_set), .ctrl_out(ctrl_out),
        .cmd_pulse(cmd_pulse), .cmd_data(cmd_data), .irq_out(irq_out)
    );

    always #5 pclk = ~pclk;

    int n_checks = 0, n_err = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [31:0]   ctrl_m = '0, cmd_m = '0, m_mask;
    logic [IW-1:0] irq_m = '0, clr_m;
    logic          pulse_m = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    always @(posedge pclk) begin
        if (!presetn) begin
            ctrl_m = '0; cmd_m = '0; irq_m = '0; pulse_m = 1'b0;
        end else begin
            m_mask  = {{8{pstrb[3]}}, {8{pstrb[2]}}, {8{pstrb[1]}}, {8{pstrb[0]}}};
            clr_m   = '0;
            pulse_m = 1'b0;
            if (psel && penable && pwrite && pready) begin
                case (paddr[AW-1:2])
                    6'd0: ctrl_m = ((ctrl_m & ~m_mask) | (pwdata & m_mask)) & CMASK;
                    6'd2: begin cmd_m = (cmd_m & ~m_mask) | (pwdata & m_mask); pulse_m = 1'b1; end
                    6'd3: clr_m = pwdata[IW-1:0] & m_mask[IW-1:0];
                    default: ;
                endcase
            end
            irq_m = (irq_m & ~clr_m) | hw_irq_set;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge pclk) begin
        #2;
        if (presetn && !finished) begin
            chk("R3 ctrl_out vs model", ctrl_out, ctrl_m);
            chk("R4 irq_out vs model", {31'b0, irq_out}, {31'b0, |irq_m});
            chk("R11/R1 cmd_pulse vs model", {31'b0, cmd_pulse}, {31'b0, pulse_m});
            chk("R11 cmd_data vs model", cmd_data, cmd_m);
            if (!(psel && penable)) chk("R7 prdata zero outside access", prdata, 32'h0);
            if (!pready)            chk("R8 pslverr outside completion", {31'b0, pslverr}, 32'h0);
        end
    end

    task automatic xfer(input logic wr, input logic [AW-1:0] addr, input logic [31:0] wd,
                        input logic [3:0] sb, input logic [31:0] exp_rd, input logic exp_err,
                        input string tag);
        int waits;
        logic [31:0] first_rd;
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wd; pstrb = sb;
        @(negedge pclk);
        penable = 1'b1;
        waits = 0;
        #1;
        first_rd = prdata;
        while (!pready && waits < 10) begin
            chk({"R7 prdata stable in wait ", tag}, prdata, first_rd);
            chk({"R8 no error in wait ", tag}, {31'b0, pslverr}, 32'h0);
            @(negedge pclk);
            #1;
            waits++;
        end
        chk({"R2 wait count ", tag}, waits, WAITS);
        if (!wr) chk({"read data ", tag}, prdata, exp_rd);
        chk({"error response ", tag}, {31'b0, pslverr}, {31'b0, exp_err});
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        #1;
        chk({"R2 pready falls ", tag}, {31'b0, pready}, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge pclk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge pclk);
        chk("R9 pready in reset", {31'b0, pready}, 32'h0);
        chk("R9 ctrl_out in reset", ctrl_out, 32'h0);
        chk("R9 irq_out in reset", {31'b0, irq_out}, 32'h0);
        chk("R9 cmd_pulse in reset", {31'b0, cmd_pulse}, 32'h0);
        chk("R9 prdata in reset", prdata, 32'h0);
        presetn = 1'b1;

        // R3 R5: full write, reserved top byte dropped
        xfer(1, 8'h00, 32'hA5A5_1234, 4'hF, 0, 0, "R3 ctrl full");
        xfer(0, 8'h00, 0, 0, 32'h00A5_1234, 0, "R5 ctrl reserved");
        // R3: single lane
        xfer(1, 8'h00, 32'hFFFF_FFFF, 4'b0010, 0, 0, "R3 ctrl lane1");
        xfer(0, 8'h00, 0, 0, 32'h00A5_FF34, 0, "R3 ctrl lane1 readback");
        // R10: low address bits ignored
        xfer(1, 8'h03, 32'h0000_0077, 4'b0001, 0, 0, "R10 ctrl via 0x03");
        xfer(0, 8'h01, 0, 0, 32'h00A5_FF77, 0, "R10 ctrl via 0x01");
        // R11 R1: command strobe, lanes 0 and 2
        xfer(1, 8'h08, 32'h1122_3344, 4'b0101, 0, 0, "R11 cmd write");
        chk("R11 cmd_data lanes", cmd_data, 32'h0022_0044);
        xfer(0, 8'h08, 0, 0, 32'h0, 0, "R11 cmd read zero");
        // R5: status read and rejected write
        hw_status = 32'hDEAD_BEEF;
        xfer(0, 8'h04, 0, 0, 32'hDEAD_BEEF, 0, "R5 status read");
        xfer(1, 8'h04, 32'h0, 4'hF, 0, 1, "R5 status write error");
        chk("R5 ctrl after status write", ctrl_out, 32'h00A5_FF77);
        // R6: unmapped
        xfer(1, 8'h10, 32'h0, 4'hF, 0, 1, "R6 unmapped write");
        chk("R6 ctrl after unmapped", ctrl_out, 32'h00A5_FF77);
        xfer(0, 8'hFC, 0, 0, 32'h0, 1, "R6 unmapped read");
        // R4: hardware set then partial clear
        @(negedge pclk); hw_irq_set = 8'h0F;
        @(negedge pclk); hw_irq_set = 8'h00;
        xfer(0, 8'h0C, 0, 0, 32'h0000_000F, 0, "R4 irq set");
        xfer(1, 8'h0C, 32'hFFFF_FF05, 4'h1, 0, 0, "R4 irq clear 0x05");
        xfer(0, 8'h0C, 0, 0, 32'h0000_000A, 0, "R4 irq after clear");
        xfer(1, 8'h0C, 32'hFFFF_FFFF, 4'h0, 0, 0, "R3 irq clear unstrobed");
        xfer(0, 8'h0C, 0, 0, 32'h0000_000A, 0, "R3 irq unstrobed kept");
        // R4: same-cycle set and clear of bit 3
        hw_irq_set = 8'h08;
        xfer(1, 8'h0C, 32'h0000_0008, 4'h1, 0, 0, "R4 set vs clear");
        hw_irq_set = 8'h00;
        xfer(0, 8'h0C, 0, 0, 32'h0000_000A, 0, "R4 set wins");
        xfer(1, 8'h0C, 32'h0000_000A, 4'h1, 0, 0, "R4 final clear");
        xfer(0, 8'h0C, 0, 0, 32'h0, 0, "R4 irq empty");
        chk("R4 irq_out low", {31'b0, irq_out}, 32'h0);
        // R9: asynchronous reset mid-run
        @(negedge pclk); #2; presetn = 1'b0; #1;
        chk("R9 ctrl after async reset", ctrl_out, 32'h0);
        chk("R9 cmd_data after async reset", cmd_data, 32'h0);
        @(negedge pclk); presetn = 1'b1;
        repeat (3) @(negedge pclk);
        report();
    end
endmodule